// File: doc/BRIEF.md
# Oversampling Serial Receiver with Buffered Character Output

This block takes an asynchronous serial line and turns each received frame into a parallel character. It is paced by a one-cycle enable pulse that arrives sixteen times per bit period. That pulse comes from a divider outside the block, which divides the system clock by 16 and by a programmable divisor. The line goes through a two-stage synchroniser. The receiver waits for the idle-high line to go low and confirms the start bit half a bit later. It then samples every following bit at its centre, least significant data bit first.

Word length (5 to 8 bits) and parity handling (none, even, odd) can be changed at run time through two small select inputs. They must be held steady while a frame is in flight. The frame is assembled in an internal shift register that is not visible at the ports. When the stop bit has been sampled, the frame moves into a holding register together with its parity and framing status, and the data-ready flag is raised. A read strobe from the consumer releases the holding register. If a new character arrives before that strobe, it replaces the old one and the overrun flag is set.

Top module: `serial_rx16`

## Requirements
- R1: The line passes through two synchroniser flops. A low level seen on a tick while idle starts a frame only if the line is still low at the 8th tick after that detection tick; otherwise the receiver goes back to idle and produces no character.
- R2: Each data, parity and stop bit is sampled 16 ticks after the previous sample point. Data bits arrive least significant first.
- R3: wlen_sel selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8.
- R4: par_sel 0 or 3 means no parity bit. 1 means even parity (data plus parity bit hold an even number of ones). 2 means odd parity. A mismatch sets parity_err for that character, and parity_err is 0 when parity is off.
- R5: Only the first stop bit is checked. If it is sampled low, frame_err is set for that character; otherwise it is 0.
- R6: For word lengths below 8, the unused upper bits of rx_data are zero.
- R7: If a character completes while data_ready is still 1 and no read strobe is present in that cycle, overrun is set and rx_data takes the new character.
- R8: A read strobe with no character completing in the same cycle clears data_ready and overrun on the next clock.
- R9: After reset all outputs are 0. The clock after the stop bit is sampled, data_ready is 1 and rx_data, parity_err and frame_err show the new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| wlen_sel | input | 2 | Data bit count select (5 + value) |
| par_sel | input | 2 | Parity mode: 0/3 none, 1 even, 2 odd |
| rd_strobe | input | 1 | Consumer has taken the character |
| rx_data | output | 8 | Buffered character, upper bits zero |
| data_ready | output | 1 | Holding register has an unread character |
| parity_err | output | 1 | Parity mismatch on the buffered character |
| frame_err | output | 1 | Stop bit was low on the buffered character |
| overrun | output | 1 | An unread character was replaced |

## Verification
The assertions assume that wlen_sel stays constant from the start of a frame until one clock after it completes. The zero-upper-bits check compares the output against the select value that was present when the character was stored. The stimulus changes the format only between frames, while the line is idle. It also never pulses the read strobe near a frame's stop sample, so a completion and a read never fall in the same cycle. Line transitions are driven just after a tick and held for 16 ticks, so every sample point falls well inside its bit.

// File: rtl/rx16_pkg.sv
package rx16_pkg;
  typedef enum logic [1:0] {
    PAR_OFF   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_OFF_B = 2'd3
  } par_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx16_sync.sv
module rx16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/rx16_frame.sv
module rx16_frame
  import rx16_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16,
  localparam int CW = $clog2(OS),
  localparam int NW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_s,
  input  logic [NW-1:0] nbits,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          perr,
  output logic          ferr
);
  localparam logic [CW-1:0] HALF_M1 = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OS - 1);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [NW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      acc  <= 1'b0;
      done <= 1'b0;
      word <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: begin
            if (!rx_s) begin
              cnt <= '0;
              st  <= ST_START;
            end
          end
          ST_START: begin
            if (cnt == HALF_M1) begin
              cnt  <= '0;
              bitn <= '0;
              sh   <= '0;
              acc  <= 1'b0;
              st   <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == FULL_M1) begin
              cnt  <= '0;
              sh   <= {rx_s, sh[DW-1:1]};
              acc  <= acc ^ rx_s;
              bitn <= bitn + 1'b1;
              if (bitn == nbits - NW'(1)) st <= par_en ? ST_PAR : ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == FULL_M1) begin
              cnt <= '0;
              acc <= acc ^ rx_s;
              st  <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == FULL_M1) begin
              cnt  <= '0;
              done <= 1'b1;
              word <= sh >> (NW'(DW) - nbits);
              perr <= par_en & (acc ^ par_odd);
              ferr <= ~rx_s;
              st   <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx16_hold.sv
module rx16_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] word,
  input  logic          perr,
  input  logic          ferr,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          ready,
  output logic          pe,
  output logic          fe,
  output logic          ov
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      ready <= 1'b0;
      pe    <= 1'b0;
      fe    <= 1'b0;
      ov    <= 1'b0;
    end else if (load) begin
      data  <= word;
      pe    <= perr;
      fe    <= ferr;
      ov    <= ready & ~rd;
      ready <= 1'b1;
    end else if (rd) begin
      ready <= 1'b0;
      ov    <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx16.sv
module serial_rx16
  import rx16_pkg::*;
#(
  parameter int DW      = 8,
  parameter int MINW    = 5,
  parameter int OS      = 16,
  parameter int SYNC_ST = 2,
  localparam int WSW    = $clog2(DW - MINW + 1),
  localparam int NW     = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           baud_tick,
  input  logic           rx_line,
  input  logic [WSW-1:0] wlen_sel,
  input  logic [1:0]     par_sel,
  input  logic           rd_strobe,
  output logic [DW-1:0]  rx_data,
  output logic           data_ready,
  output logic           parity_err,
  output logic           frame_err,
  output logic           overrun
);
  logic          rx_s;
  logic [NW-1:0] nbits;
  logic          par_en, par_odd;
  logic          frame_done;
  logic [DW-1:0] frame_word;
  logic          frame_perr, frame_ferr;
  par_sel_e      pmode;

  assign pmode   = par_sel_e'(par_sel);
  assign nbits   = NW'(MINW) + NW'(wlen_sel);
  assign par_en  = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
  assign par_odd = (pmode == PAR_ODD);

  rx16_sync #(.STAGES(SYNC_ST)) i_sync (
    .clk(clk), .rst(rst), .d_in(rx_line), .q_out(rx_s)
  );

  rx16_frame #(.DW(DW), .OS(OS)) i_frame (
    .clk(clk), .rst(rst), .tick(baud_tick), .rx_s(rx_s),
    .nbits(nbits), .par_en(par_en), .par_odd(par_odd),
    .done(frame_done), .word(frame_word),
    .perr(frame_perr), .ferr(frame_ferr)
  );

  rx16_hold #(.DW(DW)) i_hold (
    .clk(clk), .rst(rst), .load(frame_done), .word(frame_word),
    .perr(frame_perr), .ferr(frame_ferr), .rd(rd_strobe),
    .data(rx_data), .ready(data_ready), .pe(parity_err),
    .fe(frame_err), .ov(overrun)
  );
endmodule

// File: rtl/rx16_chk.sv
module rx16_chk #(
  parameter int DW  = 8,
  parameter int MINW = 5,
  parameter int WSW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_strobe,
  input logic           frame_done,
  input logic           data_ready,
  input logic           overrun,
  input logic           parity_err,
  input logic           frame_err,
  input logic [DW-1:0]  rx_data,
  input logic [WSW-1:0] wlen_sel
);
  // R8
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_strobe && !frame_done |=> !data_ready && !overrun);

  // R7
  a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
    frame_done && data_ready && !rd_strobe |=> overrun);

  // R9
  a_r9_ready_on_done: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> data_ready);

  // R9: buffered outputs only move when a character lands
  a_r9_data_held: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(rx_data) && $stable(parity_err) && $stable(frame_err));

  // R6
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> ((32'(rx_data) >> (MINW + int'($past(wlen_sel)))) == 0));

  // R7: overrun never stands without an unread character
  a_r7_ov_implies_ready: assert property (@(posedge clk) disable iff (rst)
    overrun |-> data_ready);
endmodule

bind serial_rx16 rx16_chk #(.DW(DW), .MINW(MINW), .WSW(WSW)) i_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .frame_done(frame_done),
  .data_ready(data_ready), .overrun(overrun), .parity_err(parity_err),
  .frame_err(frame_err), .rx_data(rx_data), .wlen_sel(wlen_sel)
);

// File: tb/test_serial_rx16.sv
`timescale 1ns/1ps
module test_serial_rx16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] wlen_sel = 2'd3;
  logic [1:0] par_sel = 2'd0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       data_ready, parity_err, frame_err, overrun;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  serial_rx16 i_serial_rx16 (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_line(rx_line),
    .wlen_sel(wlen_sel), .par_sel(par_sel), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .data_ready(data_ready), .parity_err(parity_err),
    .frame_err(frame_err), .overrun(overrun)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  function automatic int width_of(input logic [1:0] ws);
    return 5 + int'(ws);
  endfunction

  function automatic logic [7:0] mask_of(input logic [7:0] d, input logic [1:0] ws);
    return d & 8'((1 << width_of(ws)) - 1);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] ws,
                                   input logic [1:0] ps);
    logic x = ^mask_of(d, ws);
    return (ps == 2'd2) ? ~x : x;
  endfunction

  task automatic send(input logic [7:0] d, input logic [1:0] ws,
                      input logic [1:0] ps, input logic bad_par,
                      input logic stop_v);
    wlen_sel = ws;
    par_sel  = ps;
    wait_ticks(1);
    rx_line = 1'b0;
    wait_ticks(16);
    for (int b = 0; b < width_of(ws); b++) begin
      rx_line = d[b];
      wait_ticks(16);
    end
    if (ps == 2'd1 || ps == 2'd2) begin
      rx_line = par_bit(d, ws, ps) ^ bad_par;
      wait_ticks(16);
    end
    rx_line = stop_v;
    wait_ticks(16);
    rx_line = 1'b1;
    wait_ticks(20);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [1:0] ws, ps;
    logic       bp, sv;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset data", rx_data, 0);
    chk("R9 reset ready", data_ready, 0);
    chk("R9 reset flags", {parity_err, frame_err, overrun}, 0);

    // R1 false start: low for 3 ticks only
    wait_ticks(1);
    rx_line = 1'b0;
    wait_ticks(3);
    rx_line = 1'b1;
    wait_ticks(200);
    chk("R1 false start ignored", data_ready, 0);

    // R2 R3 directed 8-bit LSB-first
    send(8'hA5, 2'd3, 2'd0, 1'b0, 1'b1);
    chk("R2 lsb first data", rx_data, 8'hA5);
    chk("R9 ready set", data_ready, 1);
    do_read();
    chk("R8 read clears ready", data_ready, 0);

    // R6 all ones at width 5
    send(8'hFF, 2'd0, 2'd0, 1'b0, 1'b1);
    chk("R6 upper bits zero", rx_data, 8'h1F);
    do_read();

    // R4 odd parity error injected
    send(8'h3C, 2'd2, 2'd2, 1'b1, 1'b1);
    chk("R4 odd parity error", parity_err, 1);
    chk("R4 data with bad parity", rx_data, 8'h3C);
    do_read();

    // R5 framing error
    send(8'h5A, 2'd3, 2'd1, 1'b0, 1'b0);
    chk("R5 frame error", frame_err, 1);
    chk("R4 even parity ok", parity_err, 0);
    wait_ticks(40);
    chk("R1 low stop not taken as frame", data_ready, 1);
    do_read();

    // R7 overrun then R8 clear
    send(8'h11, 2'd3, 2'd0, 1'b0, 1'b1);
    send(8'h22, 2'd3, 2'd0, 1'b0, 1'b1);
    chk("R7 overrun set", overrun, 1);
    chk("R7 newer data kept", rx_data, 8'h22);
    do_read();
    chk("R8 read clears overrun", overrun, 0);

    // random frames
    for (int k = 0; k < 30; k++) begin
      d  = 8'($urandom);
      ws = 2'($urandom);
      ps = 2'($urandom);
      bp = ($urandom % 5) == 0;
      sv = ($urandom % 8) != 0;
      send(d, ws, ps, bp, sv);
      chk("R3 random data", rx_data, mask_of(d, ws));
      chk("R4 random parity flag", parity_err,
          (bp && (ps == 2'd1 || ps == 2'd2)) ? 1 : 0);
      chk("R5 random frame flag", frame_err, sv ? 0 : 1);
      chk("R7 random no overrun", overrun, 0);
      if (!sv) wait_ticks(40);
      do_read();
      chk("R8 random ready cleared", data_ready, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule